// File: doc/BRIEF.md
# Two-Level Lookahead Binary Adder

This block adds two unsigned operands and a single-bit carry-in without any clock or state. The operands are cut into slices of four bits. Each slice works out, from its own operand bits alone, whether it would pass an incoming carry straight through (slice propagate) and whether it makes a carry on its own (slice generate). It then forms its sum bits from a carry-in that a second lookahead stage supplies.

The second stage takes the propagate and generate pairs of all slices together with the global carry-in. For every slice boundary it writes the carry as a flat sum of products, so no carry passes from one slice to the next. The same stage also folds all slice pairs into one propagate/generate pair for the whole operand width. That pair is exported, so a wider adder can stack another lookahead stage on top of this one.

The width is a parameter. It must be a positive multiple of four and at most 64, and the default is 16 bits.

Top module: `cla_adder`

## Requirements
- R1: `{carry_out, sum}` equals the arithmetic value `op_a + op_b + carry_in` for every operand pair and both carry-in values, at the default width and at a width of 4.
- R2: When a slice's generate term is high, that slice's carry-out is 1 for either value of its carry-in.
- R3: When a slice's propagate term is high, that slice's carry-out equals its carry-in.
- R4: When a slice's propagate and generate terms are both low, that slice's carry-out is 0.
- R5: `blk_prop` and `blk_gen` do not change when only `carry_in` changes.
- R6: `blk_prop` and `blk_gen` are never high together, and the same holds for each slice's pair.
- R7: `blk_prop` is 1 exactly when `op_a ^ op_b` is all ones. `blk_gen` is 1 exactly when `op_a + op_b` with carry-in 0 overflows the width. `carry_out` equals `blk_gen | (blk_prop & carry_in)`.
- R8: With all inputs at zero, `sum`, `carry_out`, `blk_prop` and `blk_gen` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Carry out of the top bit |
| blk_prop | output | 1 | Whole-width propagate, independent of carry_in |
| blk_gen | output | 1 | Whole-width generate, independent of carry_in |

## Verification
Two things meet in the same evaluation: the slice-level generate/propagate terms, which are settled before any carry is known, and the global carry-in, which the second stage must carry across slices whose propagate is high. The bench brings these together with operands such as `0xFFFF + 0x0000`. Every slice then propagates, so flipping `carry_in` alone must flip `carry_out` and every sum bit while `blk_prop` and `blk_gen` stay fixed. The same is tried with a generating slice placed below propagating slices. Each result is judged against the arithmetic sum and against the expected flag values worked out from the operands.

// File: rtl/cla_pkg.sv
// Package: shared constants and the flat lookahead carry function.
// Assumes: no more than LA_TERMS positions are ever combined in one stage.
package cla_pkg;

    localparam int unsigned GROUP_W  = 4;
    localparam int unsigned LA_TERMS = 16;

    // Carry out of position k, written as a flat sum of products of the
    // propagate/generate terms at positions 0..k and the carry into position 0.
    function automatic logic la_carry(
        input logic [LA_TERMS-1:0] p,
        input logic [LA_TERMS-1:0] g,
        input logic                c0,
        input int unsigned         k
    );
        logic acc;
        logic term;
        acc = 1'b0;
        // carry-in term: survives only if every position propagates
        term = c0;
        for (int unsigned j = 0; j < LA_TERMS; j++) begin
            if (j <= k) term = term & p[j];
        end
        acc = term;
        // one product per generating position j, passed through j+1..k
        for (int unsigned j = 0; j < LA_TERMS; j++) begin
            if (j <= k) begin
                term = g[j];
                for (int unsigned m = 0; m < LA_TERMS; m++) begin
                    if (m > j && m <= k) term = term & p[m];
                end
                acc = acc | term;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/cla_bitpg.sv
// Module: per-bit propagate (xor) and generate (and) terms.
// Assumes: purely combinational; W is any positive width.
module cla_bitpg #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] bit_p,
    output logic [W-1:0] bit_g
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // one half-adder pair for each bit position
        assign bit_p[i] = in_a[i] ^ in_b[i];
        assign bit_g[i] = in_a[i] & in_b[i];
    end

endmodule

// File: rtl/cla_group4.sv
// Module: one four-bit lookahead slice. It exports its propagate and generate
// terms, which are built from the operand bits alone, and forms its sum bits
// from a carry-in that the second stage supplies.
// Assumes: GROUP_W <= LA_TERMS.
module cla_group4
    import cla_pkg::*;
(
    input  logic [GROUP_W-1:0] grp_a,
    input  logic [GROUP_W-1:0] grp_b,
    input  logic               grp_cin,
    output logic [GROUP_W-1:0] grp_sum,
    output logic               grp_prop,
    output logic               grp_gen
);

    logic [GROUP_W-1:0]  bp;
    logic [GROUP_W-1:0]  bg;
    logic [LA_TERMS-1:0] pw;
    logic [LA_TERMS-1:0] gw;
    logic [GROUP_W:0]    cv;

    cla_bitpg #(.W(GROUP_W)) u_bits (
        .in_a  (grp_a),
        .in_b  (grp_b),
        .bit_p (bp),
        .bit_g (bg)
    );

    // widen the bit terms to the width the lookahead function takes
    always_comb begin
        pw = '0;
        gw = '0;
        for (int unsigned i = 0; i < GROUP_W; i++) begin
            pw[i] = bp[i];
            gw[i] = bg[i];
        end
    end

    // slice terms: carry-in is deliberately absent here
    always_comb begin
        grp_prop = &bp;
        grp_gen  = la_carry(pw, gw, 1'b0, GROUP_W - 1);
    end

    // internal carries and sum bits, each carry taken straight from grp_cin
    always_comb begin
        cv[0] = grp_cin;
        for (int unsigned k = 0; k < GROUP_W; k++) begin
            cv[k+1] = la_carry(pw, gw, grp_cin, k);
        end
        grp_sum = bp ^ cv[GROUP_W-1:0];
    end

    // slice-level checks on the carry leaving the top bit
    always_comb begin
        if (!$isunknown({grp_a, grp_b, grp_cin})) begin
            a_r2_gen_forces_carry: assert (!grp_gen || cv[GROUP_W]);
            a_r3_prop_passes_cin:  assert (!grp_prop || (cv[GROUP_W] == grp_cin));
            a_r4_idle_kills_carry: assert (grp_prop || grp_gen || !cv[GROUP_W]);
            a_r6_slice_exclusive:  assert (!(grp_prop && grp_gen));
            a_r1_slice_arith:      assert ({cv[GROUP_W], grp_sum} ==
                                           ({1'b0, grp_a} + {1'b0, grp_b} + {{GROUP_W{1'b0}}, grp_cin}));
        end
    end

endmodule

// File: rtl/cla_carry_unit.sv
// Module: second lookahead stage. It turns the slice propagate/generate pairs
// and the global carry-in into every slice carry-in, the final carry-out, and
// one propagate/generate pair for the whole width.
// Assumes: 1 <= NGRP <= LA_TERMS.
module cla_carry_unit
    import cla_pkg::*;
#(
    parameter int unsigned NGRP = 4
) (
    input  logic [NGRP-1:0] slc_prop,
    input  logic [NGRP-1:0] slc_gen,
    input  logic            cin,
    output logic [NGRP-1:0] slc_cin,
    output logic            cout,
    output logic            all_prop,
    output logic            all_gen
);

    logic [LA_TERMS-1:0] pw;
    logic [LA_TERMS-1:0] gw;

    // widen the slice terms to the function width
    always_comb begin
        pw = '0;
        gw = '0;
        for (int unsigned i = 0; i < NGRP; i++) begin
            pw[i] = slc_prop[i];
            gw[i] = slc_gen[i];
        end
    end

    // flat carry into each slice, taken from the global carry-in
    always_comb begin
        slc_cin[0] = cin;
        for (int unsigned k = 1; k < NGRP; k++) begin
            slc_cin[k] = la_carry(pw, gw, cin, k - 1);
        end
        cout = la_carry(pw, gw, cin, NGRP - 1);
    end

    // whole-width pair, carry-in absent so an upper stage can reuse it
    always_comb begin
        all_prop = &slc_prop;
        all_gen  = la_carry(pw, gw, 1'b0, NGRP - 1);
    end

    // the composed pair must predict the final carry
    always_comb begin
        if (!$isunknown({slc_prop, slc_gen, cin})) begin
            a_r7_cout_compose: assert (cout == (all_gen | (all_prop & cin)));
            a_r6_block_exclusive: assert (!(all_prop && all_gen));
        end
    end

endmodule

// File: rtl/cla_adder.sv
// Module: top of the two-level lookahead adder. It splits the operands into
// four-bit slices and joins them through the second lookahead stage.
// Assumes: WIDTH is a positive multiple of GROUP_W and at most 64.
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             blk_prop,
    output logic             blk_gen
);

    localparam int unsigned NGRP = WIDTH / GROUP_W;

    logic [NGRP-1:0] g_prop;
    logic [NGRP-1:0] g_gen;
    logic [NGRP-1:0] g_cin;

    // parameter sanity at elaboration
    initial begin
        a_width_legal: assert ((WIDTH % GROUP_W) == 0 && NGRP >= 1 && NGRP <= LA_TERMS);
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_slice
        cla_group4 u_grp (
            .grp_a    (op_a[k*GROUP_W +: GROUP_W]),
            .grp_b    (op_b[k*GROUP_W +: GROUP_W]),
            .grp_cin  (g_cin[k]),
            .grp_sum  (sum[k*GROUP_W +: GROUP_W]),
            .grp_prop (g_prop[k]),
            .grp_gen  (g_gen[k])
        );
    end

    cla_carry_unit #(.NGRP(NGRP)) u_la2 (
        .slc_prop (g_prop),
        .slc_gen  (g_gen),
        .cin      (carry_in),
        .slc_cin  (g_cin),
        .cout     (carry_out),
        .all_prop (blk_prop),
        .all_gen  (blk_gen)
    );

    // end-to-end arithmetic and flag meaning at the ports
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            a_r1_sum_exact: assert ({carry_out, sum} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}));
            a_r7_prop_meaning: assert (blk_prop == (&(op_a ^ op_b)));
        end
    end

endmodule

// File: tb/sim_cla_adder.sv
// Bench: directed scenarios, one task each, checking the 16-bit default
// instance u0 and a 4-bit instance u1.
module sim_cla_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W0 = 16;
    localparam int W1 = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    logic [W0-1:0] a0, b0, s0;
    logic          ci0, co0, pr0, gn0;
    logic [W1-1:0] a1, b1, s1;
    logic          ci1, co1, pr1, gn1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cla_adder #(.WIDTH(W0)) u0 (
        .op_a(a0), .op_b(b0), .carry_in(ci0),
        .sum(s0), .carry_out(co0), .blk_prop(pr0), .blk_gen(gn0)
    );

    cla_adder #(.WIDTH(W1)) u1 (
        .op_a(a1), .op_b(b1), .carry_in(ci1),
        .sum(s1), .carry_out(co1), .blk_prop(pr1), .blk_gen(gn1)
    );

    task automatic chk(input string req, input logic [W0:0] act, input logic [W0:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // apply to u0 away from the clock edge, then let it settle
    task automatic drive0(input logic [W0-1:0] a, input logic [W0-1:0] b, input logic c);
        @(negedge clk);
        a0 = a; b0 = b; ci0 = c;
        #1;
    endtask

    // full check of u0 against arithmetic and flag definitions
    task automatic check0(input string tag);
        logic [W0:0] ref_sum;
        logic [W0:0] ref_nc;
        ref_sum = {1'b0, a0} + {1'b0, b0} + {{W0{1'b0}}, ci0};
        ref_nc  = {1'b0, a0} + {1'b0, b0};
        chk({"R1 ", tag}, {co0, s0}, ref_sum);
        chk({"R7 prop ", tag}, {{W0{1'b0}}, pr0}, {{W0{1'b0}}, &(a0 ^ b0)});
        chk({"R7 gen ", tag}, {{W0{1'b0}}, gn0}, {{W0{1'b0}}, ref_nc[W0]});
        chk({"R7 cout ", tag}, {{W0{1'b0}}, co0}, {{W0{1'b0}}, gn0 | (pr0 & ci0)});
        chk({"R6 ", tag}, {{W0{1'b0}}, pr0 & gn0}, '0);
    endtask

    task automatic t_reset_state;
        a0 = '0; b0 = '0; ci0 = 1'b0;
        a1 = '0; b1 = '0; ci1 = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R8 sum", {1'b0, s0}, '0);
        chk("R8 flags", {{(W0-2){1'b0}}, co0, pr0, gn0}, '0);
    endtask

    // every pair and carry-in on the 4-bit instance
    task automatic t_exhaustive4;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [4:0] r;
                    logic [4:0] rn;
                    @(negedge clk);
                    a1 = a[3:0]; b1 = b[3:0]; ci1 = c[0];
                    #1;
                    r  = {1'b0, a1} + {1'b0, b1} + {4'd0, ci1};
                    rn = {1'b0, a1} + {1'b0, b1};
                    chk("R1 width4", {12'd0, co1, s1}, {12'd0, r});
                    // R2/R3/R4 at slice level: gen forces, prop passes, idle kills
                    if (gn1) chk("R2 gen forces carry", {16'd0, co1}, 17'd1);
                    else if (pr1) chk("R3 prop passes cin", {16'd0, co1}, {16'd0, ci1});
                    else chk("R4 idle kills carry", {16'd0, co1}, 17'd0);
                    chk("R7 gen width4", {16'd0, gn1}, {16'd0, rn[4]});
                end
            end
        end
    endtask

    task automatic t_random16;
        for (int i = 0; i < 2000; i++) begin
            drive0($urandom(), $urandom(), $urandom() % 2);
            check0("random");
        end
    endtask

    // hand-picked edges of the carry chain
    task automatic t_corners;
        drive0(16'hFFFF, 16'h0000, 1'b1); check0("full chain");
        chk("R3 block prop carries cin", {16'd0, co0}, 17'd1);
        drive0(16'hFFFF, 16'h0000, 1'b0); check0("full chain no cin");
        drive0(16'hFFFF, 16'hFFFF, 1'b1); check0("all ones");
        drive0(16'h8000, 16'h8000, 1'b0); check0("top overflow");
        drive0(16'hFFF0, 16'h000F, 1'b0); check0("prop no cin");
        drive0(16'hFFF8, 16'h0008, 1'b0); check0("low gen through props");
        chk("R2 gen forces carry", {16'd0, co0}, 17'd1);
        drive0(16'h0F0F, 16'h0000, 1'b1); check0("mixed idle");
        chk("R4 idle kills carry", {16'd0, co0}, 17'd0);
    endtask

    // flipping carry_in alone must leave the block pair fixed
    task automatic t_cin_independence;
        logic p_lo, g_lo;
        logic [W0-1:0] av [4] = '{16'hFFFF, 16'hFFF8, 16'h1234, 16'h00FF};
        logic [W0-1:0] bv [4] = '{16'h0000, 16'h0008, 16'h4321, 16'hFF00};
        for (int i = 0; i < 4; i++) begin
            drive0(av[i], bv[i], 1'b0);
            p_lo = pr0; g_lo = gn0;
            drive0(av[i], bv[i], 1'b1);
            chk("R5 prop stable", {16'd0, pr0}, {16'd0, p_lo});
            chk("R5 gen stable", {16'd0, gn0}, {16'd0, g_lo});
            check0("cin flip");
        end
    endtask

    // watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_exhaustive4();
        t_corners();
        t_cin_independence();
        t_random16();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule